// File: doc/BRIEF.md
# Multiplexed Cartridge Bus Target with Latched Address Counter

This block sits on the target side of a narrow multiplexed cartridge bus. The host sends a 32-bit byte address over the 16 shared address/data lines in two halves. The falling edge of the upper-latch strobe takes the upper half. The falling edge of the lower-latch strobe takes the lower half. The host then runs a burst of halfword beats on the same lines. Each beat is either a read, where the target drives data while the read strobe is low, or a write, where the host drives data while the write strobe is low. After each beat the target moves its address forward by itself.

The upper-latch strobe also works as the chip enable. While it is high the target is deselected. In that state it reports standby, keeps its bus drivers off and ignores the beat strobes. Each rise of the strobe throws away the latched address, so a new address must be sent. All bus inputs are brought into the local clock domain through a synchroniser chain before their edges are detected. A small internal array of halfwords stands in for the cartridge storage.

Top module: `cart_bus_target`

## Requirements
- R1: After reset the target is deselected and idle: `standby` is 1 and `ad_oe` is 0.
- R2: `standby` follows the upper-latch strobe, 0 while it is low and 1 while it is high. While deselected, `ad_oe` stays 0 even when the read strobe is low.
- R3: A falling edge of `alh_n` loads AD[15:0] into address bits 31:16.
- R4: A falling edge of `all_n`, while selected with the upper half already held, loads AD[15:1] into address bits 15:1 and sets bit 0 to 0. AD[0] has no effect.
- R5: The storage holds 2^IDX_W halfwords, indexed by address bits IDX_W:1 (bits 8:1 by default). Higher bits alias.
- R6: While selected with a complete address and `rd_n` low, `ad_oe` is 1 and `ad_out` carries the halfword at the current address.
- R7: Each rising edge of `rd_n` in a complete-address state advances the address by 2.
- R8: Each rising edge of `wr_n` in a complete-address state stores the AD value present at that edge into the current address, then advances the address by 2.
- R9: A rise of `alh_n` discards the address. Until both halves are loaded again, read and write strobes store nothing, move nothing and never enable the drivers.
- R10: A new lower-half latch during a burst re-aims the address without a new upper half.
- R11: Advancing past the last storage index wraps to index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Target clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alh_n | input | 1 | Upper-address latch strobe, also the active-low chip enable |
| all_n | input | 1 | Lower-address latch strobe, active low |
| rd_n | input | 1 | Read beat strobe, active low |
| wr_n | input | 1 | Write beat strobe, active low |
| ad_in | input | 16 | Value seen on the shared address/data lines |
| ad_out | output | 16 | Read data for the shared lines |
| ad_oe | output | 1 | Drive enable for `ad_out` |
| standby | output | 1 | High while the target is deselected |

## Verification
The checker watches four rules on every cycle. The drivers are never enabled while the target is deselected or holds an incomplete address. A rise of the upper-latch strobe always returns the target to idle. An upper-latch edge loads the sampled bus value into the upper address bits. A read or write edge in a complete-address state moves the address by exactly two, and an idle target leaves its address alone. Only the bench scenarios can show data integrity: bit 0 being ignored, index aliasing and wrap, re-aiming in the middle of a burst, and strobes being ignored while the address is incomplete. The bench tests these with directed bursts and with random bursts written and then read back against a model of the storage.

// File: rtl/cart_bus_target_pkg.sv
package cart_bus_target_pkg;
  typedef enum logic [1:0] {
    TS_IDLE  = 2'd0,
    TS_UPPER = 2'd1,
    TS_READY = 2'd2
  } tgt_state_e;

  localparam int unsigned STB_NUM = 4;
  localparam int unsigned STB_ALH = 0;
  localparam int unsigned STB_ALL = 1;
  localparam int unsigned STB_RD  = 2;
  localparam int unsigned STB_WR  = 3;
endpackage

// File: rtl/cbt_sync_pipe.sv
module cbt_sync_pipe #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2,
  parameter logic        RST_V  = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [W-1:0] src;
      if (s == 0) begin : g_first
        assign src = d_i;
      end else begin : g_next
        assign src = stage_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= {W{RST_V}};
        else        stage_q[s] <= src;
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/cbt_edge_detect.sv
module cbt_edge_detect #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] fall_o,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '1;
    else        prev_q <= lvl_i;
  end

  generate
    for (genvar i = 0; i < W; i++) begin : g_edge
      assign fall_o[i] =  prev_q[i] & ~lvl_i[i];
      assign rise_o[i] = ~prev_q[i] &  lvl_i[i];
    end
  endgenerate
endmodule

// File: rtl/cbt_addr_track.sv
module cbt_addr_track
  import cart_bus_target_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_i,
  input  logic          alh_fall_i,
  input  logic          alh_rise_i,
  input  logic          all_fall_i,
  input  logic          rd_rise_i,
  input  logic          wr_rise_i,
  input  logic [DW-1:0] ad_i,
  output tgt_state_e    state_o,
  output logic [AW-1:0] addr_o,
  output logic          wr_en_o
);
  localparam int unsigned STEP = DW / 8;

  tgt_state_e    state_q, state_d;
  logic [AW-1:0] addr_q, addr_d;
  logic          beat;

  assign beat = (state_q == TS_READY) && sel_i && (rd_rise_i || wr_rise_i);

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    if (alh_rise_i) begin
      state_d = TS_IDLE;
    end else if (alh_fall_i) begin
      addr_d[AW-1:DW] = ad_i;
      state_d         = TS_UPPER;
    end else if (all_fall_i && sel_i && (state_q != TS_IDLE)) begin
      addr_d[DW-1:0] = {ad_i[DW-1:1], 1'b0};
      state_d        = TS_READY;
    end else if (beat) begin
      addr_d = addr_q + AW'(STEP);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TS_IDLE;
      addr_q  <= '0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
    end
  end

  assign wr_en_o = beat && wr_rise_i && !alh_rise_i && !alh_fall_i && !all_fall_i;
  assign state_o = state_q;
  assign addr_o  = addr_q;
endmodule

// File: rtl/cbt_halfword_store.sv
module cbt_halfword_store #(
  parameter int unsigned IDX_W = 8,
  parameter int unsigned DW    = 16
) (
  input  logic             clk,
  input  logic             we_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[idx_i] <= wdata_i;
  end

  assign rdata_o = mem[idx_i];
endmodule

// File: rtl/cart_bus_target.sv
module cart_bus_target
  import cart_bus_target_pkg::*;
#(
  parameter int unsigned AW     = 32,
  parameter int unsigned DW     = 16,
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alh_n,
  input  logic          all_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [DW-1:0] ad_in,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  output logic          standby
);
  logic [1:0]         rst_pipe_q;
  logic               rst_int_n;
  logic [STB_NUM-1:0] stb_raw, stb_lvl, stb_fall, stb_rise;
  logic [DW-1:0]      ad_q;
  tgt_state_e         state;
  logic [AW-1:0]      addr;
  logic               wr_en;
  logic               sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  assign stb_raw[STB_ALH] = alh_n;
  assign stb_raw[STB_ALL] = all_n;
  assign stb_raw[STB_RD]  = rd_n;
  assign stb_raw[STB_WR]  = wr_n;

  cbt_sync_pipe #(.W(STB_NUM), .STAGES(STAGES), .RST_V(1'b1)) u_stb_sync (
    .clk(clk), .rst_n(rst_int_n), .d_i(stb_raw), .q_o(stb_lvl)
  );

  cbt_sync_pipe #(.W(DW), .STAGES(STAGES), .RST_V(1'b0)) u_ad_sync (
    .clk(clk), .rst_n(rst_int_n), .d_i(ad_in), .q_o(ad_q)
  );

  cbt_edge_detect #(.W(STB_NUM)) u_edge (
    .clk(clk), .rst_n(rst_int_n), .lvl_i(stb_lvl),
    .fall_o(stb_fall), .rise_o(stb_rise)
  );

  assign sel = ~stb_lvl[STB_ALH];

  cbt_addr_track #(.AW(AW), .DW(DW)) u_track (
    .clk(clk), .rst_n(rst_int_n), .sel_i(sel),
    .alh_fall_i(stb_fall[STB_ALH]), .alh_rise_i(stb_rise[STB_ALH]),
    .all_fall_i(stb_fall[STB_ALL]),
    .rd_rise_i(stb_rise[STB_RD]), .wr_rise_i(stb_rise[STB_WR]),
    .ad_i(ad_q), .state_o(state), .addr_o(addr), .wr_en_o(wr_en)
  );

  cbt_halfword_store #(.IDX_W(IDX_W), .DW(DW)) u_store (
    .clk(clk), .we_i(wr_en), .idx_i(addr[IDX_W:1]),
    .wdata_i(ad_q), .rdata_o(ad_out)
  );

  assign ad_oe   = (state == TS_READY) && sel && ~stb_lvl[STB_RD];
  assign standby = ~sel;
endmodule

// File: rtl/cart_bus_target_chk.sv
module cart_bus_target_chk
  import cart_bus_target_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ad_oe,
  input logic          standby,
  input tgt_state_e    state,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] ad_q,
  input logic          alh_fall,
  input logic          alh_rise,
  input logic          all_fall,
  input logic          rd_rise,
  input logic          wr_rise
);
  // R2: drivers stay off while the target is deselected
  a_r2_no_drive_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    standby |-> !ad_oe);

  // R9: drivers need a complete address
  a_r9_oe_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |-> (state == TS_READY));

  // R9: a rise of the chip enable returns the target to idle
  a_r9_rise_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    alh_rise |=> (state == TS_IDLE));

  // R3: upper half loaded from the sampled bus
  a_r3_upper_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (alh_fall && !alh_rise) |=> (addr[AW-1:DW] == $past(ad_q)));

  // R7 and R8: one beat moves the address by one halfword
  a_r7_beat_step: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == TS_READY) && !standby && (rd_rise || wr_rise)
      && !alh_rise && !alh_fall && !all_fall)
    |=> (addr == $past(addr) + AW'(2)));

  // R9: an idle target keeps its address still
  a_r9_idle_still: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == TS_IDLE) && !alh_fall) |=> $stable(addr));
endmodule

bind cart_bus_target cart_bus_target_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ad_oe(ad_oe), .standby(standby),
  .state(state), .addr(addr), .ad_q(ad_q),
  .alh_fall(stb_fall[0]), .alh_rise(stb_rise[0]), .all_fall(stb_fall[1]),
  .rd_rise(stb_rise[2]), .wr_rise(stb_rise[3])
);

// File: tb/cart_bus_target_tb_top.sv
module cart_bus_target_tb_top;
  localparam int IDX_W = 8;
  localparam int DEPTH = 1 << IDX_W;

  logic        clk, rst_n;
  logic        alh_n, all_n, rd_n, wr_n;
  logic [15:0] ad_in, ad_out;
  logic        ad_oe, standby;

  int n_run, n_fail;
  bit done;
  logic [15:0] model [DEPTH];
  logic [31:0] cur;

  cart_bus_target dut_i (
    .clk(clk), .rst_n(rst_n), .alh_n(alh_n), .all_n(all_n),
    .rd_n(rd_n), .wr_n(wr_n), .ad_in(ad_in), .ad_out(ad_out),
    .ad_oe(ad_oe), .standby(standby)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int idx_of(input logic [31:0] a);
    return int'(a[IDX_W:1]);
  endfunction

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sel_upper(input logic [15:0] hi);
    ad_in = hi; wait_cyc(2);
    alh_n = 1'b0; wait_cyc(6);
    cur[31:16] = hi;
  endtask

  task automatic set_lower(input logic [15:0] lo);
    ad_in = lo; wait_cyc(2);
    all_n = 1'b0; wait_cyc(6);
    all_n = 1'b1; wait_cyc(4);
    cur[15:0] = {lo[15:1], 1'b0};
  endtask

  task automatic desel();
    alh_n = 1'b1; wait_cyc(6);
  endtask

  task automatic wr_beat(input logic [15:0] d, input bit upd);
    ad_in = d; wait_cyc(2);
    wr_n = 1'b0; wait_cyc(6);
    wr_n = 1'b1; wait_cyc(6);
    if (upd) begin
      model[idx_of(cur)] = d;
      cur = cur + 32'd2;
    end
  endtask

  task automatic rd_beat(input string req);
    ad_in = 16'h0;
    rd_n = 1'b0; wait_cyc(6);
    check(req, {15'd0, ad_oe, ad_out}, {15'd0, 1'b1, model[idx_of(cur)]});
    rd_n = 1'b1; wait_cyc(6);
    cur = cur + 32'd2;
  endtask

  initial begin
    wait_cyc(150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    n_run = 0; n_fail = 0; done = 0; cur = '0;
    alh_n = 1; all_n = 1; rd_n = 1; wr_n = 1; ad_in = 0;
    rst_n = 0;
    void'($urandom(32'd1234));
    wait_cyc(4);
    // R1: reset state
    check("R1 standby", {31'd0, standby}, 32'd1);
    check("R1 oe", {31'd0, ad_oe}, 32'd0);
    rst_n = 1; wait_cyc(4);

    // R2: read strobe while deselected
    rd_n = 0; wait_cyc(6);
    check("R2 oe deselected", {31'd0, ad_oe}, 32'd0);
    rd_n = 1; wait_cyc(6);

    // R3 R6 R7 R8: directed burst
    sel_upper(16'h1234);
    check("R2 selected", {31'd0, standby}, 32'd0);
    set_lower(16'h0010);
    for (int i = 0; i < 4; i++) wr_beat(16'hA000 + 16'(i), 1);
    desel();
    check("R2 deselected", {31'd0, standby}, 32'd1);
    sel_upper(16'h1234); set_lower(16'h0010);
    for (int i = 0; i < 4; i++) rd_beat("R6 R7 R8 burst read");
    desel();

    // R4: bit 0 ignored
    sel_upper(16'h1234); set_lower(16'h0011);
    rd_beat("R4 bit0 ignored");
    desel();

    // R5: upper bits alias
    sel_upper(16'hABCD); set_lower(16'h0212);
    rd_beat("R5 alias");
    desel();

    // R9: strobes ignored with upper half only
    sel_upper(16'h0000);
    rd_n = 0; wait_cyc(6);
    check("R9 oe incomplete", {31'd0, ad_oe}, 32'd0);
    rd_n = 1; wait_cyc(6);
    wr_beat(16'hDEAD, 0);
    set_lower(16'h0010);
    rd_beat("R9 no store no move");
    desel();

    // R10: re-aim during burst
    sel_upper(16'h0001); set_lower(16'h0010);
    rd_beat("R10 before re-aim");
    set_lower(16'h0014);
    rd_beat("R10 after re-aim");
    desel();

    // R11: wrap from last index
    sel_upper(16'h0000); set_lower(16'h01FE);
    wr_beat(16'h5A5A, 1);
    wr_beat(16'hC3C3, 1);
    desel();
    sel_upper(16'h0000); set_lower(16'h0000);
    rd_beat("R11 wrap to index 0");
    desel();

    // random bursts
    for (int b = 0; b < 25; b++) begin
      logic [31:0] a;
      int len;
      a = $urandom;
      len = 1 + ($urandom % 6);
      sel_upper(a[31:16]); set_lower(a[15:0]);
      for (int k = 0; k < len; k++) wr_beat(16'($urandom), 1);
      desel();
      sel_upper(a[31:16]); set_lower(a[15:0]);
      for (int k = 0; k < len; k++) rd_beat("R6 R8 random burst");
      desel();
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule